// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block keeps the rename map for a small architectural register file in an out-of-order core. Every architectural register has one entry holding the tag of the youngest in-flight instruction that will write it, a data value, and a ready flag. The rename stage reads source entries through two lookup ports and claims a destination through a rename write port. Finished instructions drive a result bus carrying a tag, a value and their sequence number. Any pending entry whose tag matches takes the value and becomes ready.

When a branch is decoded, the whole map is copied into one of four snapshot slots, and the slot number is returned to the caller. A snapshot keeps receiving results, but only from producers older than its branch. Age is decided by comparing wrapping sequence numbers. A restored snapshot therefore already holds every value that an older instruction produced after the branch was decoded. A correctly predicted branch releases its slot. A mispredicted branch puts its snapshot back into the live map and releases its own slot and every slot belonging to a younger branch.

Top module: `ckpt_rat`

## Requirements
- R1: After a synchronous reset, every live entry is ready with tag 0 and value 0, all four snapshot slots are free, `br_full` is 0 and `br_slot` is 0.
- R2: The two lookup ports return the tag, value and ready flag of the live entry they address, combinationally, from the current state.
- R3: When `bc_valid` is 1, every live entry that is not ready and holds tag `bc_tag` takes `bc_value` and becomes ready on the next clock edge. Ready entries are not changed.
- R4: A rename sets the addressed live entry's tag to `ren_tag`, clears its ready flag and keeps its value. When a broadcast hits the same register in the same cycle, the rename wins.
- R5: `br_slot` shows the lowest-numbered free slot. A branch allocation stores a copy of the live map into that slot, with the same-cycle broadcast applied and the same-cycle rename not applied, and records `br_seq` with it.
- R6: `br_full` is 1 exactly when all four slots are in use. An allocation while full changes nothing.
- R7: A broadcast updates a pending, tag-matching entry of an occupied snapshot only when the snapshot is younger than the producer. The snapshot counts as younger when (snapshot seq − `bc_seq`) mod 32 is nonzero and below 16.
- R8: A correct resolve frees slot `res_slot` and leaves the live map unchanged. A resolve naming a free slot has no effect.
- R9: A mispredict naming an occupied slot loads that snapshot into the live map, with the same-cycle broadcast applied under the R7 age rule. It frees that slot and every occupied slot younger than it, and any same-cycle rename, allocation or resolve is ignored. A mispredict naming a free slot is ignored.
- R10: Snapshots older than the mispredicted branch remain occupied and unchanged, apart from broadcast updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_reg_a | input | 3 | Lookup port A register index |
| lkp_tag_a | output | 3 | Lookup port A tag |
| lkp_val_a | output | 16 | Lookup port A value |
| lkp_rdy_a | output | 1 | Lookup port A ready flag |
| lkp_reg_b | input | 3 | Lookup port B register index |
| lkp_tag_b | output | 3 | Lookup port B tag |
| lkp_val_b | output | 16 | Lookup port B value |
| lkp_rdy_b | output | 1 | Lookup port B ready flag |
| ren_we | input | 1 | Rename write enable |
| ren_reg | input | 3 | Destination register being renamed |
| ren_tag | input | 3 | New producer tag |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 3 | Broadcast producer tag |
| bc_value | input | 16 | Broadcast result value |
| bc_seq | input | 5 | Broadcast producer sequence number |
| br_alloc | input | 1 | Branch decoded, take snapshot |
| br_seq | input | 5 | Sequence number of the branch |
| br_slot | output | 2 | Slot the next allocation will use |
| br_full | output | 1 | All snapshot slots occupied |
| res_ok | input | 1 | Branch resolved as correctly predicted |
| res_slot | input | 2 | Slot of the resolved branch |
| mp_valid | input | 1 | Branch mispredicted |
| mp_slot | input | 2 | Slot of the mispredicted branch |

## Verification
The bench drives a rename and a broadcast to the same register in one cycle. A design with the wrong priority would leave that register ready with a stale value. It sends results from producers that sit between two snapshots. A design without the age check would write them into the older snapshot, and a later restore would then bring back a value the branch must not see. The random phase keeps the sequence numbers wrapping and issues mispredicts with other commands in the same cycle, including mispredicts naming free slots. This catches a plain magnitude compare, which frees the wrong slots after a wrap, and a design that lets a rename or allocation through during a restore, which corrupts the restored map.

// File: rtl/crat_pkg.sv
`timescale 1ns/1ps
package crat_pkg;
    localparam int NREGS  = 8;
    localparam int REG_W  = $clog2(NREGS);
    localparam int TAG_W  = 3;
    localparam int DATA_W = 16;
    localparam int SEQ_W  = 5;
    localparam int NSNAP  = 4;
    localparam int SLOT_W = $clog2(NSNAP);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
        logic              valid;
    } ent_t;

    typedef ent_t [NREGS-1:0] map_t;
    typedef map_t [NSNAP-1:0] bank_t;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
        logic [SEQ_W-1:0]  seq;
    } bcast_t;

    // a is younger than b under wrapping arithmetic
    function automatic logic is_younger(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return (diff != '0) && !diff[SEQ_W-1];
    endfunction

    function automatic map_t apply_bcast(map_t m, bcast_t b, logic en);
        map_t r;
        r = m;
        for (int i = 0; i < NREGS; i++) begin
            if (en && b.vld && !m[i].valid && (m[i].tag == b.tag)) begin
                r[i].value = b.value;
                r[i].valid = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic map_t reset_map();
        map_t r;
        for (int i = 0; i < NREGS; i++) begin
            r[i].tag   = '0;
            r[i].value = '0;
            r[i].valid = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/crat_live_map.sv
`timescale 1ns/1ps
module crat_live_map
    import crat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bcast_t           bc,
    input  logic             ren_we,
    input  logic [REG_W-1:0] ren_reg,
    input  logic [TAG_W-1:0] ren_tag,
    input  logic             restore_en,
    input  map_t             restore_map,
    output map_t             live,
    output map_t             live_bc
);
    map_t live_q;
    map_t live_nxt;

    always_comb begin
        live_bc = apply_bcast(live_q, bc, 1'b1);
        if (restore_en) begin
            live_nxt = restore_map;
        end else begin
            live_nxt = live_bc;
            if (ren_we) begin
                live_nxt[ren_reg].tag   = ren_tag;
                live_nxt[ren_reg].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live_q <= reset_map();
        else     live_q <= live_nxt;
    end

    assign live = live_q;
endmodule

// File: rtl/crat_snap_slot.sv
`timescale 1ns/1ps
module crat_snap_slot
    import crat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bcast_t           bc,
    input  logic             cap_en,
    input  map_t             cap_map,
    input  logic [SEQ_W-1:0] cap_seq,
    input  logic             free_en,
    output map_t             snap,
    output logic [SEQ_W-1:0] seq,
    output logic             used
);
    map_t             snap_q;
    logic [SEQ_W-1:0] seq_q;
    logic             used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= reset_map();
            seq_q  <= '0;
            used_q <= 1'b0;
        end else if (cap_en) begin
            snap_q <= cap_map;
            seq_q  <= cap_seq;
            used_q <= 1'b1;
        end else begin
            snap_q <= apply_bcast(snap_q, bc, used_q && is_younger(seq_q, bc.seq));
            if (free_en) used_q <= 1'b0;
        end
    end

    assign snap = snap_q;
    assign seq  = seq_q;
    assign used = used_q;
endmodule

// File: rtl/crat_slot_pick.sv
`timescale 1ns/1ps
module crat_slot_pick
    import crat_pkg::*;
(
    input  logic [NSNAP-1:0]  used,
    output logic [SLOT_W-1:0] free_idx,
    output logic              full
);
    always_comb begin
        free_idx = '0;
        full     = 1'b1;
        for (int j = NSNAP-1; j >= 0; j--) begin
            if (!used[j]) begin
                free_idx = SLOT_W'(j);
                full     = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ckpt_rat.sv
`timescale 1ns/1ps
module ckpt_rat
    import crat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  lkp_reg_a,
    output logic [TAG_W-1:0]  lkp_tag_a,
    output logic [DATA_W-1:0] lkp_val_a,
    output logic              lkp_rdy_a,
    input  logic [REG_W-1:0]  lkp_reg_b,
    output logic [TAG_W-1:0]  lkp_tag_b,
    output logic [DATA_W-1:0] lkp_val_b,
    output logic              lkp_rdy_b,
    input  logic              ren_we,
    input  logic [REG_W-1:0]  ren_reg,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic [SEQ_W-1:0]  bc_seq,
    input  logic              br_alloc,
    input  logic [SEQ_W-1:0]  br_seq,
    output logic [SLOT_W-1:0] br_slot,
    output logic              br_full,
    input  logic              res_ok,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic              mp_valid,
    input  logic [SLOT_W-1:0] mp_slot
);
    bcast_t            bc;
    map_t              live;
    map_t              live_bc;
    map_t              restore_map;
    bank_t             snap_maps;
    logic [SEQ_W-1:0]  snap_seq [NSNAP];
    logic [NSNAP-1:0]  snap_used;
    logic [NSNAP-1:0]  cap_v;
    logic [NSNAP-1:0]  free_v;
    logic [SLOT_W-1:0] free_idx;
    logic              full;
    logic              mp_eff;

    assign bc = '{vld: bc_valid, tag: bc_tag, value: bc_value, seq: bc_seq};

    crat_slot_pick u_pick (
        .used     (snap_used),
        .free_idx (free_idx),
        .full     (full)
    );

    assign mp_eff      = mp_valid && snap_used[mp_slot];
    assign restore_map = apply_bcast(snap_maps[mp_slot], bc,
                                     is_younger(snap_seq[mp_slot], bc_seq));

    always_comb begin
        for (int j = 0; j < NSNAP; j++) begin
            cap_v[j]  = !mp_eff && br_alloc && !full && (free_idx == SLOT_W'(j));
            free_v[j] = 1'b0;
            if (mp_eff) begin
                free_v[j] = (SLOT_W'(j) == mp_slot) ||
                            (snap_used[j] && is_younger(snap_seq[j], snap_seq[mp_slot]));
            end else if (res_ok && (res_slot == SLOT_W'(j))) begin
                free_v[j] = 1'b1;
            end
        end
    end

    crat_live_map u_live (
        .clk         (clk),
        .rst         (rst),
        .bc          (bc),
        .ren_we      (ren_we && !mp_eff),
        .ren_reg     (ren_reg),
        .ren_tag     (ren_tag),
        .restore_en  (mp_eff),
        .restore_map (restore_map),
        .live        (live),
        .live_bc     (live_bc)
    );

    for (genvar g = 0; g < NSNAP; g++) begin : g_slot
        map_t             s_map;
        logic [SEQ_W-1:0] s_seq;
        logic             s_used;
        crat_snap_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .bc      (bc),
            .cap_en  (cap_v[g]),
            .cap_map (live_bc),
            .cap_seq (br_seq),
            .free_en (free_v[g]),
            .snap    (s_map),
            .seq     (s_seq),
            .used    (s_used)
        );
        assign snap_maps[g] = s_map;
        assign snap_seq[g]  = s_seq;
        assign snap_used[g] = s_used;
    end

    assign lkp_tag_a = live[lkp_reg_a].tag;
    assign lkp_val_a = live[lkp_reg_a].value;
    assign lkp_rdy_a = live[lkp_reg_a].valid;
    assign lkp_tag_b = live[lkp_reg_b].tag;
    assign lkp_val_b = live[lkp_reg_b].value;
    assign lkp_rdy_b = live[lkp_reg_b].valid;
    assign br_slot   = free_idx;
    assign br_full   = full;
endmodule

// File: rtl/crat_checks.sv
`timescale 1ns/1ps
module crat_checks
    import crat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ren_we,
    input logic [REG_W-1:0]  ren_reg,
    input logic [TAG_W-1:0]  ren_tag,
    input logic              bc_valid,
    input logic [TAG_W-1:0]  bc_tag,
    input logic [DATA_W-1:0] bc_value,
    input logic [REG_W-1:0]  lkp_reg_a,
    input logic              br_alloc,
    input logic              br_full,
    input logic              res_ok,
    input logic              mp_valid,
    input logic [SLOT_W-1:0] mp_slot,
    input map_t              live,
    input bank_t             snap_maps,
    input logic [NSNAP-1:0]  snap_used
);
    AST_RENAME_WINS: assert property (@(posedge clk) disable iff (rst)
        (ren_we && !mp_valid) |=>
        (live[$past(ren_reg)].tag == $past(ren_tag) && !live[$past(ren_reg)].valid)); // R4

    AST_BCAST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && !mp_valid && !(ren_we && ren_reg == lkp_reg_a) &&
         !live[lkp_reg_a].valid && live[lkp_reg_a].tag == bc_tag) |=>
        (live[$past(lkp_reg_a)].valid && live[$past(lkp_reg_a)].value == $past(bc_value))); // R3

    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (br_alloc && br_full && !mp_valid && !res_ok) |=> (snap_used == $past(snap_used))); // R6

    AST_RESOLVE_KEEPS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (res_ok && !mp_valid && !ren_we && !bc_valid) |=> (live == $past(live))); // R8

    AST_RESTORE_IMAGE: assert property (@(posedge clk) disable iff (rst)
        (mp_valid && snap_used[mp_slot] && !bc_valid) |=> (live == $past(snap_maps[mp_slot]))); // R9

    AST_RESTORE_FREES: assert property (@(posedge clk) disable iff (rst)
        (mp_valid && snap_used[mp_slot]) |=> !snap_used[$past(mp_slot)]); // R9
endmodule

bind ckpt_rat crat_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .ren_we    (ren_we),
    .ren_reg   (ren_reg),
    .ren_tag   (ren_tag),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .bc_value  (bc_value),
    .lkp_reg_a (lkp_reg_a),
    .br_alloc  (br_alloc),
    .br_full   (br_full),
    .res_ok    (res_ok),
    .mp_valid  (mp_valid),
    .mp_slot   (mp_slot),
    .live      (live),
    .snap_maps (snap_maps),
    .snap_used (snap_used)
);

// File: tb/ckpt_rat_tb_top.sv
`timescale 1ns/1ps
module ckpt_rat_tb_top;
    import crat_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [REG_W-1:0]  lkp_reg_a, lkp_reg_b;
    logic [TAG_W-1:0]  lkp_tag_a, lkp_tag_b;
    logic [DATA_W-1:0] lkp_val_a, lkp_val_b;
    logic              lkp_rdy_a, lkp_rdy_b;
    logic              ren_we;
    logic [REG_W-1:0]  ren_reg;
    logic [TAG_W-1:0]  ren_tag;
    logic              bc_valid;
    logic [TAG_W-1:0]  bc_tag;
    logic [DATA_W-1:0] bc_value;
    logic [SEQ_W-1:0]  bc_seq;
    logic              br_alloc;
    logic [SEQ_W-1:0]  br_seq;
    logic [SLOT_W-1:0] br_slot;
    logic              br_full;
    logic              res_ok;
    logic [SLOT_W-1:0] res_slot;
    logic              mp_valid;
    logic [SLOT_W-1:0] mp_slot;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    map_t             m_live;
    map_t             m_snap [NSNAP];
    logic [SEQ_W-1:0] m_seq  [NSNAP];
    logic             m_used [NSNAP];

    always #2 clk = ~clk;

    ckpt_rat dut_i (
        .clk(clk), .rst(rst),
        .lkp_reg_a(lkp_reg_a), .lkp_tag_a(lkp_tag_a), .lkp_val_a(lkp_val_a), .lkp_rdy_a(lkp_rdy_a),
        .lkp_reg_b(lkp_reg_b), .lkp_tag_b(lkp_tag_b), .lkp_val_b(lkp_val_b), .lkp_rdy_b(lkp_rdy_b),
        .ren_we(ren_we), .ren_reg(ren_reg), .ren_tag(ren_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value), .bc_seq(bc_seq),
        .br_alloc(br_alloc), .br_seq(br_seq), .br_slot(br_slot), .br_full(br_full),
        .res_ok(res_ok), .res_slot(res_slot), .mp_valid(mp_valid), .mp_slot(mp_slot)
    );

    // snapshot seq s is after producer seq p within half the wrap range
    function automatic bit m_after(logic [SEQ_W-1:0] s, logic [SEQ_W-1:0] p);
        logic [SEQ_W-1:0] d;
        d = s - p;
        return (d != 0) && (int'(d) < (1 << (SEQ_W-1)));
    endfunction

    function automatic map_t m_take(map_t m, bit en);
        map_t r = m;
        if (en && bc_valid)
            foreach (r[i])
                if (r[i].valid == 1'b0 && r[i].tag == bc_tag) begin
                    r[i].value = bc_value;
                    r[i].valid = 1'b1;
                end
        return r;
    endfunction

    function automatic int m_first_free();
        for (int j = 0; j < NSNAP; j++) if (!m_used[j]) return j;
        return -1;
    endfunction

    task automatic m_reset();
        foreach (m_live[i]) begin
            m_live[i].tag = '0; m_live[i].value = '0; m_live[i].valid = 1'b1;
        end
        for (int j = 0; j < NSNAP; j++) begin
            m_used[j] = 1'b0; m_seq[j] = '0; m_snap[j] = m_live;
        end
    endtask

    task automatic m_step();
        map_t             nl, lb;
        map_t             ns [NSNAP];
        logic             nu [NSNAP];
        logic [SEQ_W-1:0] nq [NSNAP];
        bit mpe;
        int k;
        mpe = mp_valid && m_used[mp_slot];
        lb  = m_take(m_live, 1'b1);
        for (int j = 0; j < NSNAP; j++) begin
            ns[j] = m_take(m_snap[j], m_used[j] && m_after(m_seq[j], bc_seq));
            nu[j] = m_used[j];
            nq[j] = m_seq[j];
        end
        if (mpe) begin
            nl = m_take(m_snap[mp_slot], m_after(m_seq[mp_slot], bc_seq));
            for (int j = 0; j < NSNAP; j++)
                if (j == int'(mp_slot) || (m_used[j] && m_after(m_seq[j], m_seq[mp_slot])))
                    nu[j] = 1'b0;
        end else begin
            nl = lb;
            if (ren_we) begin
                nl[ren_reg].tag = ren_tag;
                nl[ren_reg].valid = 1'b0;
            end
            if (res_ok) nu[res_slot] = 1'b0;
            k = m_first_free();
            if (br_alloc && k >= 0) begin
                ns[k] = lb; nq[k] = br_seq; nu[k] = 1'b1;
            end
        end
        m_live = nl;
        for (int j = 0; j < NSNAP; j++) begin
            m_snap[j] = ns[j]; m_used[j] = nu[j]; m_seq[j] = nq[j];
        end
    endtask

    task automatic check(input string req, input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int ff;
        bit all_used;
        for (int r = 0; r < NREGS; r += 2) begin
            lkp_reg_a = REG_W'(r);
            lkp_reg_b = REG_W'(r + 1);
            #0.2;
            check(req, {lkp_tag_a, lkp_val_a, lkp_rdy_a} == m_live[r], "lookup A",
                  32'({lkp_tag_a, lkp_val_a, lkp_rdy_a}), 32'(m_live[r]));
            check(req, {lkp_tag_b, lkp_val_b, lkp_rdy_b} == m_live[r+1], "lookup B",
                  32'({lkp_tag_b, lkp_val_b, lkp_rdy_b}), 32'(m_live[r+1]));
        end
        ff = m_first_free();
        all_used = (ff < 0);
        check(req, br_full == all_used, "br_full", 32'(br_full), 32'(all_used));
        if (!all_used)
            check(req, int'(br_slot) == ff, "br_slot", 32'(br_slot), 32'(ff));
    endtask

    task automatic idle();
        ren_we = 0; ren_reg = '0; ren_tag = '0;
        bc_valid = 0; bc_tag = '0; bc_value = '0; bc_seq = '0;
        br_alloc = 0; br_seq = '0; res_ok = 0; res_slot = '0;
        mp_valid = 0; mp_slot = '0;
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        m_step();
        @(negedge clk);
        check_all(req);
        #0.2;
        idle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [SEQ_W-1:0] cur;
        void'($urandom(32'h5eed_1234));
        idle();
        lkp_reg_a = '0; lkp_reg_b = '0;
        rst = 1;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");

        // R1: idle after reset keeps the reset image
        tick("R1");
        // R4: rename clears ready
        ren_we = 1; ren_reg = 3'd1; ren_tag = 3'd5; tick("R4");
        // R4: rename beats same-cycle broadcast to the same register
        ren_we = 1; ren_reg = 3'd1; ren_tag = 3'd6;
        bc_valid = 1; bc_tag = 3'd5; bc_value = 16'h1234; bc_seq = 5'd0; tick("R4");
        // R3: broadcast captured by pending entry
        bc_valid = 1; bc_tag = 3'd6; bc_value = 16'hBEEF; bc_seq = 5'd0; tick("R3");
        ren_we = 1; ren_reg = 3'd2; ren_tag = 3'd3; tick("R4");
        // R5: fill snapshot slots
        br_alloc = 1; br_seq = 5'd1; tick("R5");
        ren_we = 1; ren_reg = 3'd3; ren_tag = 3'd2; tick("R4");
        br_alloc = 1; br_seq = 5'd3; tick("R5");
        br_alloc = 1; br_seq = 5'd4; tick("R5");
        br_alloc = 1; br_seq = 5'd5; tick("R5");
        // R6: allocation while full is dropped
        br_alloc = 1; br_seq = 5'd6; tick("R6");
        // R7: producer seq 2 updates only snapshots taken after it
        bc_valid = 1; bc_tag = 3'd2; bc_value = 16'h2222; bc_seq = 5'd2; tick("R7");
        bc_valid = 1; bc_tag = 3'd3; bc_value = 16'h3333; bc_seq = 5'd0; tick("R7");
        // R8: resolve frees, live unchanged; second resolve on free slot is a no-op
        res_ok = 1; res_slot = 2'd3; tick("R8");
        res_ok = 1; res_slot = 2'd3; tick("R8");
        // R9: mispredict slot 1 restores and frees slots 1 and 2
        mp_valid = 1; mp_slot = 2'd1; ren_we = 1; ren_reg = 3'd4; ren_tag = 3'd7; tick("R9");
        // R10: slot 0 survives, next allocation reuses slot 1
        br_alloc = 1; br_seq = 5'd7; tick("R10");
        // R9: mispredict on a free slot is ignored
        mp_valid = 1; mp_slot = 2'd3; ren_we = 1; ren_reg = 3'd5; ren_tag = 3'd1; tick("R9");
        mp_valid = 1; mp_slot = 2'd0; br_alloc = 1; br_seq = 5'd8; res_ok = 1; res_slot = 2'd1;
        tick("R9");

        // R2: constrained random mix, sequence numbers wrap
        cur = 5'd9;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 1) == 0) begin
                ren_we = 1; ren_reg = REG_W'($urandom); ren_tag = TAG_W'($urandom);
                cur = cur + 1'b1;
            end
            if ($urandom_range(0, 1) == 0) begin
                bc_valid = 1; bc_tag = TAG_W'($urandom); bc_value = DATA_W'($urandom);
                bc_seq = cur - SEQ_W'($urandom_range(0, 5));
            end
            if ($urandom_range(0, 4) == 0) begin
                br_alloc = 1; br_seq = cur; cur = cur + 1'b1;
            end
            if ($urandom_range(0, 9) == 0) begin
                res_ok = 1; res_slot = SLOT_W'($urandom);
            end
            if ($urandom_range(0, 14) == 0) begin
                mp_valid = 1; mp_slot = SLOT_W'($urandom);
            end
            tick("R2");
        end
        done = 1;
        summary();
    end
endmodule